// File: doc/BRIEF.md
# Floating-Point Operand-Error Detector

This block sits in front of the commit stage of a floating-point datapath. It screens every issued operation for operand combinations that have no meaningful result. The datapath presents an operation code, a destination operand and a source operand together with a valid strobe. Each operand is an 80-bit extended-precision value. Both operands are classified in parallel: zero, infinity, quiet or signalling NaN, sign, and magnitude greater than one. A per-operation rule set then decides whether the operation is an operand error.

On a detected error the block raises a registered per-operation flag and sets a sticky status bit. That bit stays set until software-side logic pulses a clear strobe. With the exception enabled, a one-cycle exception request goes to the dispatcher. With the exception masked, the block instead offers a replacement result, a positive quiet NaN whose mantissa bits are all ones. The only exception to this is integer conversion, which never gets a substitute. The block does no arithmetic and does not dispatch handlers.

Top module: `fp_operr_unit`

## Requirements
- R1: Operand layout is bit 79 sign, bits 78:64 biased exponent, bits 63:0 mantissa with bit 63 the explicit integer bit and bit 62 the quiet bit. An all-ones exponent marks infinity when bits 62:0 are zero and NaN otherwise. For add (op code 0), the operation is an error exactly when both operands are infinities of opposite sign.
- R2: Subtract (op code 1, destination minus source) is an error exactly when both operands are infinities of the same sign.
- R3: Multiply (op code 2) is an error when one operand is zero (exponent and mantissa zero, either sign) and the other is an infinity.
- R4: Divide (op code 3, destination over source) is an error for zero over zero and for infinity over infinity, in any sign combination.
- R5: Square root (op code 4, source operand) is an error when the source is an infinity of either sign, or is negative and neither zero nor NaN. Minus zero is not an error.
- R6: Arccosine (op code 6) and arcsine (op code 7) are errors when the source is an infinity or has magnitude above 1.0. Hyperbolic arctangent (op code 8) is an error when the magnitude is above 1.0. Exactly plus or minus 1.0 is not an error.
- R7: Integer conversion (op code 5) is an error when the source is a quiet NaN or plus infinity. Minus infinity and a signalling NaN are not errors. This op code never produces a substitute NaN.
- R8: A NaN operand never causes an error except under R7, and op codes 9 to 15 never cause one.
- R9: `out_valid` and `operr_flag` appear exactly one clock after the input is accepted. With `in_valid` low, neither is raised.
- R10: `status_operr` is set by any detected error and then holds. It is cleared by `status_clr` only. When a clear and an error meet in the same cycle, the bit stays set.
- R11: With `exc_en` low, an error under R1 to R6 raises `nan_valid` with `nan_result` equal to sign 0, exponent 7FFF hex and all 64 mantissa bits set. In this case `exc_req` stays low.
- R12: With `exc_en` high, an error pulses `exc_req` alongside `operr_flag` and leaves `nan_valid` low.
- R13: During and right after a synchronous reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 4 | Operation code |
| opnd_a | input | 80 | Destination operand |
| opnd_b | input | 80 | Source operand |
| exc_en | input | 1 | Operand-error exception enabled |
| status_clr | input | 1 | Clears the sticky status bit |
| out_valid | output | 1 | Result of screening valid |
| operr_flag | output | 1 | This operation is an operand error |
| exc_req | output | 1 | Exception request pulse |
| nan_valid | output | 1 | Substitute result offered |
| nan_result | output | 80 | Substitute default NaN |
| status_operr | output | 1 | Sticky operand-error status |

## Verification
The checker watches the following on every cycle: the one-cycle latency and the absence of spurious output, the mutual exclusion of the exception request and the substitute, and the exact substitute bit pattern. It also covers the holding of the sticky bit, and the flagging of infinite square roots, opposite-infinity additions and conversions that must not substitute. The remaining rules can only be shown by the bench's operand scenarios. These are the full per-operation error table, the ±1.0 range boundary, the NaN and signed-zero exemptions, and the clear-versus-set collision on the status bit.

// File: rtl/fpoe_pkg.sv
package fpoe_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_MUL   = 4'd2,
    OP_DIV   = 4'd3,
    OP_SQRT  = 4'd4,
    OP_TOINT = 4'd5,
    OP_ACOS  = 4'd6,
    OP_ASIN  = 4'd7,
    OP_ATANH = 4'd8
  } fpoe_op_e;

  typedef struct packed {
    logic zero;
    logic inf;
    logic nan;
    logic qnan;
    logic neg;
    logic gt_one;
  } fpoe_class_t;
endpackage

// File: rtl/fpoe_classify.sv
module fpoe_classify #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0]  value,
  output fpoe_pkg::fpoe_class_t cls
);
  localparam int FP_W = 1 + EXP_W + MAN_W;
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] BIAS    = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [MAN_W-1:0] ONE_MAN = {1'b1, {(MAN_W-1){1'b0}}};

  logic             sgn;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;
  logic             frac_zero;

  always_comb begin
    sgn       = value[FP_W-1];
    expo      = value[FP_W-2 -: EXP_W];
    man       = value[MAN_W-1:0];
    frac_zero = (man[MAN_W-2:0] == '0);
    cls.zero  = (expo == '0) && (man == '0);
    cls.inf   = (expo == EXP_MAX) && frac_zero;
    cls.nan   = (expo == EXP_MAX) && !frac_zero;
    cls.qnan  = cls.nan && man[MAN_W-2];
    cls.neg   = sgn;
    cls.gt_one = !cls.nan &&
                 ((expo > BIAS) || ((expo == BIAS) && (man > ONE_MAN)));
  end
endmodule

// File: rtl/fpoe_rules.sv
module fpoe_rules (
  input  logic [3:0]            op,
  input  fpoe_pkg::fpoe_class_t ca,
  input  fpoe_pkg::fpoe_class_t cb,
  output logic                  err,
  output logic                  no_subst
);
  import fpoe_pkg::*;

  logic both_inf;

  always_comb begin
    both_inf = ca.inf && cb.inf;
    no_subst = 1'b0;
    err      = 1'b0;
    case (op)
      OP_ADD:   err = both_inf && (ca.neg != cb.neg);
      OP_SUB:   err = both_inf && (ca.neg == cb.neg);
      OP_MUL:   err = (ca.zero && cb.inf) || (ca.inf && cb.zero);
      OP_DIV:   err = (ca.zero && cb.zero) || both_inf;
      OP_SQRT:  err = cb.inf || (cb.neg && !cb.zero && !cb.nan);
      OP_TOINT: begin
        err      = cb.qnan || (cb.inf && !cb.neg);
        no_subst = 1'b1;
      end
      OP_ACOS, OP_ASIN: err = cb.inf || cb.gt_one;
      OP_ATANH: err = cb.gt_one;
      default:  err = 1'b0;
    endcase
  end
endmodule

// File: rtl/fp_operr_unit.sv
module fp_operr_unit #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  parameter int OP_W  = 4,
  parameter int NOPND = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [OP_W-1:0]        op,
  input  logic [EXP_W+MAN_W:0]   opnd_a,
  input  logic [EXP_W+MAN_W:0]   opnd_b,
  input  logic                   exc_en,
  input  logic                   status_clr,
  output logic                   out_valid,
  output logic                   operr_flag,
  output logic                   exc_req,
  output logic                   nan_valid,
  output logic [EXP_W+MAN_W:0]   nan_result,
  output logic                   status_operr
);
  import fpoe_pkg::*;

  localparam int FP_W = 1 + EXP_W + MAN_W;
  localparam logic [FP_W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b1}}};

  logic [FP_W-1:0] opnd [NOPND];
  fpoe_class_t     cls  [NOPND];
  logic            err_c;
  logic            no_subst_c;
  logic            hit;

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar g = 0; g < NOPND; g++) begin : g_cls
    fpoe_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .value (opnd[g]),
      .cls   (cls[g])
    );
  end

  fpoe_rules u_rules (
    .op       (op[3:0]),
    .ca       (cls[0]),
    .cb       (cls[1]),
    .err      (err_c),
    .no_subst (no_subst_c)
  );

  assign hit = in_valid && err_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      operr_flag   <= 1'b0;
      exc_req      <= 1'b0;
      nan_valid    <= 1'b0;
      nan_result   <= '0;
      status_operr <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      operr_flag   <= hit;
      exc_req      <= hit && exc_en;
      nan_valid    <= hit && !exc_en && !no_subst_c;
      nan_result   <= (hit && !exc_en && !no_subst_c) ? DEF_NAN : '0;
      status_operr <= (status_operr && !status_clr) || hit;
    end
  end
endmodule

// File: rtl/fpoe_chk.sv
module fpoe_chk #(
  parameter int FP_W = 80
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [3:0]      op,
  input logic [FP_W-1:0] opnd_a,
  input logic [FP_W-1:0] opnd_b,
  input logic            exc_en,
  input logic            status_clr,
  input logic            out_valid,
  input logic            operr_flag,
  input logic            exc_req,
  input logic            nan_valid,
  input logic [FP_W-1:0] nan_result,
  input logic            status_operr
);
  localparam int MAN_W = 64;
  localparam int EXP_W = FP_W - 1 - MAN_W;
  localparam logic [FP_W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b1}}};

  logic b_inf, a_inf;
  assign b_inf = (opnd_b[FP_W-2 -: EXP_W] == '1) && (opnd_b[MAN_W-2:0] == '0);
  assign a_inf = (opnd_a[FP_W-2 -: EXP_W] == '1) && (opnd_a[MAN_W-2:0] == '0);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !operr_flag)); // R9
  AST_EXC_XOR_NAN: assert property (@(posedge clk) disable iff (rst)
    !(exc_req && nan_valid)); // R12
  AST_MASKED_NO_EXC: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !exc_en) |=> !exc_req); // R11
  AST_NAN_PATTERN: assert property (@(posedge clk) disable iff (rst)
    nan_valid |-> (nan_result == DEF_NAN)); // R11
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (status_operr && !status_clr) |=> status_operr); // R10
  AST_FLAG_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    operr_flag |-> status_operr); // R10
  AST_TOINT_NO_SUBST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd5) |=> !nan_valid); // R7
  AST_SQRT_INF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd4 && b_inf) |=> operr_flag); // R5
  AST_ADD_OPP_INF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd0 && a_inf && b_inf && (opnd_a[FP_W-1] != opnd_b[FP_W-1]))
      |=> operr_flag); // R1
endmodule

bind fp_operr_unit fpoe_chk #(.FP_W(FP_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .op           (op[3:0]),
  .opnd_a       (opnd_a),
  .opnd_b       (opnd_b),
  .exc_en       (exc_en),
  .status_clr   (status_clr),
  .out_valid    (out_valid),
  .operr_flag   (operr_flag),
  .exc_req      (exc_req),
  .nan_valid    (nan_valid),
  .nan_result   (nan_result),
  .status_operr (status_operr)
);

// File: tb/tb_fp_operr_unit.sv
module tb_fp_operr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [79:0] opnd_a = '0;
  logic [79:0] opnd_b = '0;
  logic        exc_en = 1'b0;
  logic        status_clr = 1'b0;
  logic        out_valid, operr_flag, exc_req, nan_valid, status_operr;
  logic [79:0] nan_result;

  always #2 clk = ~clk;

  fp_operr_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .exc_en(exc_en),
    .status_clr(status_clr), .out_valid(out_valid),
    .operr_flag(operr_flag), .exc_req(exc_req), .nan_valid(nan_valid),
    .nan_result(nan_result), .status_operr(status_operr)
  );

  localparam logic [79:0] DNAN  = {1'b0, 15'h7FFF, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [79:0] PINF  = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] NINF  = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] PZERO = '0;
  localparam logic [79:0] NZERO = {1'b1, 79'h0};
  localparam logic [79:0] QNAN  = {1'b0, 15'h7FFF, 64'hC000_0000_0000_0000};
  localparam logic [79:0] NQNAN = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};
  localparam logic [79:0] SNAN  = {1'b0, 15'h7FFF, 64'hA000_0000_0000_0000};
  localparam logic [79:0] P_ONE = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] N_ONE = {1'b1, 15'h3FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] P1P5  = {1'b0, 15'h3FFF, 64'hC000_0000_0000_0000};
  localparam logic [79:0] N1P5  = {1'b1, 15'h3FFF, 64'hC000_0000_0000_0000};
  localparam logic [79:0] PHALF = {1'b0, 15'h3FFE, 64'h8000_0000_0000_0000};
  localparam logic [79:0] NTWO  = {1'b1, 15'h4000, 64'h8000_0000_0000_0000};
  localparam logic [79:0] FIVE  = {1'b0, 15'h4001, 64'hA000_0000_0000_0000};

  typedef struct {
    logic  flag;
    logic  exc;
    logic  nanv;
    logic  stat;
    string tag;
  } exp_t;

  exp_t queue_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  logic model_stat = 1'b0;
  logic done = 1'b0;

  function automatic logic f_inf(logic [79:0] x);
    return (x[78:64] == 15'h7FFF) && (x[62:0] == '0);
  endfunction
  function automatic logic f_nan(logic [79:0] x);
    return (x[78:64] == 15'h7FFF) && (x[62:0] != '0);
  endfunction
  function automatic logic f_zero(logic [79:0] x);
    return x[78:0] == '0;
  endfunction
  function automatic logic f_big(logic [79:0] x);
    if (f_nan(x)) return 1'b0;
    if (x[78:64] > 15'h3FFF) return 1'b1;
    return (x[78:64] == 15'h3FFF) && (x[63:0] > 64'h8000_0000_0000_0000);
  endfunction

  function automatic logic f_expect(logic [3:0] o, logic [79:0] a, logic [79:0] b);
    case (o)
      4'd0: return f_inf(a) && f_inf(b) && (a[79] != b[79]);
      4'd1: return f_inf(a) && f_inf(b) && (a[79] == b[79]);
      4'd2: return (f_zero(a) && f_inf(b)) || (f_inf(a) && f_zero(b));
      4'd3: return (f_zero(a) && f_zero(b)) || (f_inf(a) && f_inf(b));
      4'd4: return f_inf(b) || (b[79] && !f_zero(b) && !f_nan(b));
      4'd5: return (f_nan(b) && b[62]) || (f_inf(b) && !b[79]);
      4'd6, 4'd7: return f_inf(b) || f_big(b);
      4'd8: return f_big(b);
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [79:0] a, input logic [79:0] b,
                       input logic en, input logic clr, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b; exc_en = en; status_clr = clr;
    e.flag = f_expect(o, a, b);
    e.exc  = e.flag && en;
    e.nanv = e.flag && !en && (o != 4'd5);
    model_stat = (model_stat && !clr) || e.flag;
    e.stat = model_stat;
    e.tag  = tag;
    queue_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; status_clr = 1'b0;
  endtask

  task automatic check(input logic ok, input string tag, input logic [79:0] act, input logic [79:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: pops expected items as results appear
  always @(posedge clk) begin
    #1;
    if (!rst && out_valid) begin
      if (queue_q.size() == 0) begin
        check(1'b0, "R9 unexpected out_valid", 80'd1, 80'd0);
      end else begin
        exp_t e;
        logic [3:0] act, expv;
        logic ok;
        e = queue_q.pop_front();
        act  = {operr_flag, exc_req, nan_valid, status_operr};
        expv = {e.flag, e.exc, e.nanv, e.stat};
        ok = (act == expv) && (!e.nanv || nan_result == DNAN);
        check(ok, e.tag, {act, nan_result[75:0]}, {expv, DNAN[75:0]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({out_valid, operr_flag, exc_req, nan_valid, status_operr} == 5'b0 && nan_result == '0,
          "R13 reset state", {75'd0, out_valid, operr_flag, exc_req, nan_valid, status_operr}, 80'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(!out_valid && !status_operr, "R13 after reset", {78'd0, out_valid, status_operr}, 80'd0);

    drive(4'd0, PINF, NINF, 1'b0, 1'b0, "R1 +inf + -inf");
    drive(4'd0, PINF, PINF, 1'b0, 1'b0, "R1 +inf + +inf");
    drive(4'd0, NINF, FIVE, 1'b0, 1'b0, "R1 -inf + 5");
    drive(4'd1, PINF, PINF, 1'b0, 1'b0, "R2 +inf - +inf");
    drive(4'd1, NINF, NINF, 1'b1, 1'b0, "R2 -inf - -inf enabled");
    drive(4'd1, PINF, NINF, 1'b0, 1'b0, "R2 +inf - -inf");
    drive(4'd2, PZERO, PINF, 1'b0, 1'b0, "R3 0 * inf");
    drive(4'd2, NINF, NZERO, 1'b0, 1'b0, "R3 -inf * -0");
    drive(4'd2, PZERO, FIVE, 1'b0, 1'b0, "R3 0 * 5");
    drive(4'd3, PZERO, NZERO, 1'b0, 1'b0, "R4 0 / -0");
    drive(4'd3, NINF, PINF, 1'b1, 1'b0, "R4 inf / inf enabled");
    drive(4'd3, FIVE, PZERO, 1'b0, 1'b0, "R4 5 / 0");
    drive(4'd4, 80'h0, NTWO, 1'b0, 1'b0, "R5 sqrt(-2)");
    drive(4'd4, 80'h0, PINF, 1'b0, 1'b0, "R5 sqrt(+inf)");
    drive(4'd4, 80'h0, NZERO, 1'b0, 1'b0, "R5 sqrt(-0)");
    drive(4'd4, 80'h0, FIVE, 1'b0, 1'b0, "R5 sqrt(5)");
    drive(4'd6, 80'h0, P_ONE, 1'b0, 1'b0, "R6 acos(1)");
    drive(4'd6, 80'h0, P1P5, 1'b0, 1'b0, "R6 acos(1.5)");
    drive(4'd7, 80'h0, NINF, 1'b0, 1'b0, "R6 asin(-inf)");
    drive(4'd7, 80'h0, PHALF, 1'b0, 1'b0, "R6 asin(0.5)");
    drive(4'd8, 80'h0, N_ONE, 1'b0, 1'b0, "R6 atanh(-1)");
    drive(4'd8, 80'h0, N1P5, 1'b0, 1'b0, "R6 atanh(-1.5)");
    drive(4'd5, 80'h0, QNAN, 1'b0, 1'b0, "R7 toint(qnan) masked");
    drive(4'd5, 80'h0, PINF, 1'b1, 1'b0, "R7 toint(+inf) enabled");
    drive(4'd5, 80'h0, NINF, 1'b0, 1'b0, "R7 toint(-inf)");
    drive(4'd5, 80'h0, SNAN, 1'b0, 1'b0, "R7 toint(snan)");
    drive(4'd0, PINF, QNAN, 1'b0, 1'b0, "R8 inf + nan");
    drive(4'd4, 80'h0, NQNAN, 1'b0, 1'b0, "R8 sqrt(-nan)");
    drive(4'd9, PINF, NINF, 1'b0, 1'b0, "R8 op 9");
    drive(4'd15, PZERO, PZERO, 1'b1, 1'b0, "R8 op 15");
    drive(4'd3, PZERO, PZERO, 1'b0, 1'b0, "R11 masked substitute");
    drive(4'd2, PINF, PZERO, 1'b1, 1'b0, "R12 enabled request");
    idle();
    idle();
    check(!out_valid && !operr_flag, "R9 idle no output", {78'd0, out_valid, operr_flag}, 80'd0);

    // R10: clear with no error, then verify status reads zero through a clean op
    drive(4'd0, FIVE, FIVE, 1'b0, 1'b1, "R10 clear with clean op");
    drive(4'd0, FIVE, FIVE, 1'b0, 1'b0, "R10 stays clear");
    drive(4'd1, PINF, PINF, 1'b0, 1'b0, "R10 set again");
    drive(4'd0, FIVE, FIVE, 1'b0, 1'b0, "R10 holds");
    drive(4'd3, PINF, NINF, 1'b0, 1'b1, "R10 clear loses to error");
    drive(4'd0, FIVE, FIVE, 1'b0, 1'b0, "R10 holds after collision");
    idle();
    @(negedge clk); status_clr = 1'b1; model_stat = 1'b0;
    @(negedge clk); status_clr = 1'b0;
    check(!status_operr, "R10 clear strobe alone", {79'd0, status_operr}, 80'd0);
    idle();
    idle();
    check(queue_q.size() == 0, "R9 all results seen", queue_q.size(), 80'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule